// File: doc/BRIEF.md
# Banked VRAM Window Mapper

This block sits between a 64 KB host memory aperture and a video memory that is far larger than the aperture. Each host byte access is turned into one or more video memory byte accesses. A bank register supplies the base address, and the host offset within the aperture supplies the rest. The aperture can be split into two 32 KB halves, each with its own bank register. The bank base step is 4 KB by default or 16 KB on request.

The block handles two kinds of packed-pixel access. In chained (linear) access, one host byte maps to one memory byte. In unchained (planar) access, one host byte fans out to four or eight consecutive memory bytes, gated by a plane mask, and reads return the OR of the selected bytes. The block also holds the graphics mode register and the mode-extension register. Writing the extension register trims the upper halves of the set/reset, enable set/reset and plane mask registers.

The video memory is outside the block. It is reached through eight byte lanes, each lane with its own address and enable. The memory is synchronous: read data for a request returns on the lanes in the cycle after the request.

Top module: `vram_window_mapper`

## Requirements
- R1: After reset every register reads 0x00 and `host_rvalid` is low.
- R2: Registers are selected by `reg_sel` (0 = graphics group, 1 = sequencer group) and `reg_idx`. Graphics 0x09 is the bank 0 register, 0x0A the bank 1 register, 0x0B the extension register, 0x00 set/reset and 0x01 enable set/reset. Sequencer 0x02 is the plane mask and 0x04 the memory mode register; memory mode bit 3 set selects chained access. Every register reads back what was written, except as stated in R3 and R4. Any other index reads 0x00.
- R3: Graphics register 0x05 stores shift-256 (bit 6), shift register (bit 5), host odd/even (bit 4) and read mode (bit 3). It also stores the write mode in its low bits: 3 bits when extension bit 1 is set at the write, 2 bits otherwise. Bit 7 reads 0. The effective write mode, both on readback and for steering, is the 3-bit value when extension bit 1 is set, and only its low 2 bits otherwise.
- R4: Writing the extension register with bit 1 clear clears bits 7:4 of set/reset and enable set/reset. Writing it with bit 3 clear clears bits 7:4 of the plane mask. While extension bit 1 is clear, writes to set/reset and enable set/reset store only their low nibble. While extension bit 3 is clear, plane mask writes store only their low nibble.
- R5: With extension bit 0 set, host offsets 0x0000–0x7FFF use bank 0. Offsets 0x8000–0xFFFF use bank 1 with the offset reduced by 0x8000. With bit 0 clear, the whole 16-bit offset uses bank 0.
- R6: The bank base is the bank value times 4 KB, or times 16 KB when extension bit 5 is set. In unchained access the base is further multiplied by 4.
- R7: A host offset at or above 0x10000 (`host_off[16]` set) makes no memory request. A read at such an offset returns 0x00.
- R8: In chained access, a host byte maps to the single memory byte at base + offset, on lane 0 only, regardless of the plane mask.
- R9: In unchained access with the narrow fan-out, lane i (0..3) addresses base + offset×4 + i. Lane i is enabled when plane mask bit i is set. A read returns the OR of the enabled lanes.
- R10: Unchained access uses the wide fan-out when the effective write mode is 4 or 5, or when it is 1 with extension bit 1 set. In the wide fan-out, lane i (0..7) addresses base + offset×8 + i and is gated by plane mask bit i.
- R11: Every lane address wraps modulo 2^VRAM_AW.
- R12: Read data is valid on `host_rdata` with `host_rvalid` high in the cycle after a read request; a write never raises `host_rvalid`. A register write takes effect for host accesses from the next cycle on, so an access in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register group: 0 graphics, 1 sequencer |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected index |
| host_req | input | 1 | Host aperture access request |
| host_we | input | 1 | Host access is a write |
| host_off | input | 17 | Host offset; bit 16 marks out of range |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Merged read byte |
| host_rvalid | output | 1 | Read data valid |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_lane_en | output | 8 | Per-lane enable |
| mem_addr | output | 8×VRAM_AW | Per-lane byte address, lane 0 lowest |
| mem_wdata | output | 8 | Byte written on all enabled lanes |
| mem_rdata | input | 64 | Per-lane read bytes, one cycle after request |

## Verification
Two functions can fall in the same cycle: a register update (bank or extension) and a host access that depends on it. The bench writes the bank 0 register and issues a host write in the same cycle. It then checks that the byte lands at the address given by the old bank and that the address given by the new bank is still empty. A following access must use the new bank. The scoreboard also catches any read response raised by a write, or one that is missing for a read.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_LANES = 8;
    localparam int OFF_W     = 17;

    localparam logic [7:0] GX_SETRST  = 8'h00;
    localparam logic [7:0] GX_ENSR    = 8'h01;
    localparam logic [7:0] GX_MODE    = 8'h05;
    localparam logic [7:0] GX_BANK0   = 8'h09;
    localparam logic [7:0] GX_BANK1   = 8'h0A;
    localparam logic [7:0] GX_EXT     = 8'h0B;
    localparam logic [7:0] SQ_PMASK   = 8'h02;
    localparam logic [7:0] SQ_MEMMODE = 8'h04;

    typedef enum logic [1:0] {FAN_ONE, FAN_FOUR, FAN_EIGHT} fan_e;

    typedef struct packed {
        logic       shift256;
        logic       shift_reg;
        logic       host_oe;
        logic       read_mode;
        logic [2:0] wmode;
    } mode_t;

    // Configuration the address steering needs
    typedef struct packed {
        logic [7:0] bank0;
        logic [7:0] bank1;
        logic [7:0] pmask;
        logic       chained;
        logic       split;
        logic       coarse;
        logic       wide_ext;
        logic [2:0] wmode;     // effective write mode
    } map_cfg_t;

    function automatic logic [2:0] eff_wmode(input logic [2:0] wm, input logic wide_ext);
        return wide_ext ? wm : {1'b0, wm[1:0]};
    endfunction

    function automatic fan_e pick_fan(input logic chained, input logic [2:0] wm,
                                      input logic wide_ext);
        if (chained) return FAN_ONE;
        if (wm == 3'd4 || wm == 3'd5 || (wm == 3'd1 && wide_ext)) return FAN_EIGHT;
        return FAN_FOUR;
    endfunction

    function automatic logic [3:0] fan_count(input fan_e f);
        case (f)
            FAN_ONE:  return 4'd1;
            FAN_FOUR: return 4'd4;
            default:  return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/vwm_regs.sv
module vwm_regs
    import vwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_idx,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output map_cfg_t   cfg
);
    logic [7:0] bank0, bank1, ext, setrst, ensr, pmask, memmode;
    mode_t      mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank0   <= '0;
            bank1   <= '0;
            ext     <= '0;
            setrst  <= '0;
            ensr    <= '0;
            pmask   <= '0;
            memmode <= '0;
            mode    <= '0;
        end else if (reg_wr) begin
            if (!reg_sel) begin
                case (reg_idx)
                    GX_SETRST: setrst <= ext[1] ? reg_wdata : {4'h0, reg_wdata[3:0]};
                    GX_ENSR:   ensr   <= ext[1] ? reg_wdata : {4'h0, reg_wdata[3:0]};
                    GX_MODE: begin
                        mode.shift256  <= reg_wdata[6];
                        mode.shift_reg <= reg_wdata[5];
                        mode.host_oe   <= reg_wdata[4];
                        mode.read_mode <= reg_wdata[3];
                        mode.wmode     <= ext[1] ? reg_wdata[2:0] : {1'b0, reg_wdata[1:0]};
                    end
                    GX_BANK0:  bank0 <= reg_wdata;
                    GX_BANK1:  bank1 <= reg_wdata;
                    GX_EXT: begin
                        ext <= reg_wdata;
                        if (!reg_wdata[1]) begin
                            setrst[7:4] <= 4'h0;
                            ensr[7:4]   <= 4'h0;
                        end
                        if (!reg_wdata[3]) pmask[7:4] <= 4'h0;
                    end
                    default: ;
                endcase
            end else begin
                case (reg_idx)
                    SQ_PMASK:   pmask   <= ext[3] ? reg_wdata : {4'h0, reg_wdata[3:0]};
                    SQ_MEMMODE: memmode <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (!reg_sel) begin
            case (reg_idx)
                GX_SETRST: reg_rdata = setrst;
                GX_ENSR:   reg_rdata = ensr;
                GX_MODE:   reg_rdata = {1'b0, mode.shift256, mode.shift_reg, mode.host_oe,
                                        mode.read_mode, eff_wmode(mode.wmode, ext[1])};
                GX_BANK0:  reg_rdata = bank0;
                GX_BANK1:  reg_rdata = bank1;
                GX_EXT:    reg_rdata = ext;
                default:   reg_rdata = 8'h00;
            endcase
        end else begin
            case (reg_idx)
                SQ_PMASK:   reg_rdata = pmask;
                SQ_MEMMODE: reg_rdata = memmode;
                default:    reg_rdata = 8'h00;
            endcase
        end
    end

    always_comb begin
        cfg.bank0    = bank0;
        cfg.bank1    = bank1;
        cfg.pmask    = pmask;
        cfg.chained  = memmode[3];
        cfg.split    = ext[0];
        cfg.coarse   = ext[5];
        cfg.wide_ext = ext[1];
        cfg.wmode    = eff_wmode(mode.wmode, ext[1]);
    end

    // R4: extension write with bit 3 clear leaves no upper plane-mask bits
    assert_ext_clr_mask_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !reg_sel && reg_idx == GX_EXT && !reg_wdata[3] |=> pmask[7:4] == 4'h0);
    // R4: extension write with bit 1 clear trims set/reset registers
    assert_ext_clr_sr_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !reg_sel && reg_idx == GX_EXT && !reg_wdata[1]
        |=> setrst[7:4] == 4'h0 && ensr[7:4] == 4'h0);
    // R3: mode write without extension bit 1 stores a 2-bit write mode
    assert_mode_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !reg_sel && reg_idx == GX_MODE && !ext[1] |=> !mode.wmode[2]);
endmodule

// File: rtl/vwm_addr.sv
module vwm_addr
    import vwm_pkg::*;
#(
    parameter int VRAM_AW = 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  map_cfg_t                     cfg,
    input  logic                         host_req,
    input  logic                         host_we,
    input  logic [OFF_W-1:0]             host_off,
    input  logic [BYTE_W-1:0]            host_wdata,
    output logic                         mem_en,
    output logic                         mem_we,
    output logic [MAX_LANES-1:0]         mem_lane_en,
    output logic [MAX_LANES*VRAM_AW-1:0] mem_addr,
    output logic [BYTE_W-1:0]            mem_wdata
);
    localparam int AW = VRAM_AW;

    fan_e         fan;
    logic [3:0]   fan_cnt;
    logic         hi_half;
    logic [15:0]  win_off;
    logic [7:0]   bank;
    logic [4:0]   shamt;
    logic [31:0]  scaled;
    logic [AW-1:0] start_a;

    always_comb begin
        fan     = pick_fan(cfg.chained, cfg.wmode, cfg.wide_ext);
        fan_cnt = fan_count(fan);
        hi_half = cfg.split && host_off[15];
        win_off = cfg.split ? {1'b0, host_off[14:0]} : host_off[15:0];
        bank    = hi_half ? cfg.bank1 : cfg.bank0;
        shamt   = (cfg.coarse ? 5'd14 : 5'd12) + (cfg.chained ? 5'd0 : 5'd2);
        case (fan)
            FAN_ONE:  scaled = {16'h0, win_off};
            FAN_FOUR: scaled = {14'h0, win_off, 2'b00};
            default:  scaled = {13'h0, win_off, 3'b000};
        endcase
        start_a = AW'({24'h0, bank} << shamt) + AW'(scaled);
    end

    assign mem_en    = host_req && !host_off[16];
    assign mem_we    = mem_en && host_we;
    assign mem_wdata = host_wdata;

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        assign mem_addr[g*AW +: AW] = start_a + AW'(g);
        assign mem_lane_en[g] = mem_en && (4'(g) < fan_cnt) && (cfg.chained || cfg.pmask[g]);
    end

    // R7: out-of-range offsets make no memory request
    assert_oob_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        host_req && host_off[16] |-> !mem_en && mem_lane_en == '0);
    // R8: chained access touches lane 0 only
    assert_chain_one_R8: assert property (@(posedge clk) disable iff (rst)
        mem_en && cfg.chained |-> mem_lane_en == 8'h01);
    // R9: unchained lanes stay inside the plane mask
    assert_mask_subset_R9: assert property (@(posedge clk) disable iff (rst)
        mem_en && !cfg.chained |-> (mem_lane_en & ~cfg.pmask) == '0);
    // R11: neighbouring lanes are consecutive modulo the memory size
    assert_lane_step_R11: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> mem_addr[2*AW-1:AW] == AW'(mem_addr[AW-1:0] + 1'b1));
endmodule

// File: rtl/vwm_rmerge.sv
module vwm_rmerge
    import vwm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_req,
    input  logic [MAX_LANES-1:0]        lane_en,
    input  logic [MAX_LANES*BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0]           host_rdata,
    output logic                        host_rvalid
);
    logic [MAX_LANES-1:0] lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q      <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_req;
            lane_q      <= rd_req ? lane_en : '0;
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < MAX_LANES; i++)
            if (lane_q[i]) host_rdata = host_rdata | mem_rdata[i*BYTE_W +: BYTE_W];
    end

    // R12: a response is only produced for a read issued one cycle earlier
    assert_rvalid_src_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !host_rvalid);
endmodule

// File: rtl/vram_window_mapper.sv
module vram_window_mapper
    import vwm_pkg::*;
#(
    parameter int VRAM_AW = 20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_wr,
    input  logic                           reg_sel,
    input  logic [7:0]                     reg_idx,
    input  logic [7:0]                     reg_wdata,
    output logic [7:0]                     reg_rdata,
    input  logic                           host_req,
    input  logic                           host_we,
    input  logic [16:0]                    host_off,
    input  logic [7:0]                     host_wdata,
    output logic [7:0]                     host_rdata,
    output logic                           host_rvalid,
    output logic                           mem_en,
    output logic                           mem_we,
    output logic [7:0]                     mem_lane_en,
    output logic [8*VRAM_AW-1:0]           mem_addr,
    output logic [7:0]                     mem_wdata,
    input  logic [63:0]                    mem_rdata
);
    map_cfg_t cfg;

    vwm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    vwm_addr #(.VRAM_AW(VRAM_AW)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_off    (host_off),
        .host_wdata  (host_wdata),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_lane_en (mem_lane_en),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    vwm_rmerge u_merge (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (host_req && !host_we),
        .lane_en     (mem_lane_en),
        .mem_rdata   (mem_rdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    // R12: every read is answered in the following cycle
    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (rst)
        host_req && !host_we |=> host_rvalid);
    // R12: writes never raise a read response
    assert_wr_silent_R12: assert property (@(posedge clk) disable iff (rst)
        host_req && host_we |=> !host_rvalid);
    // R7: out-of-range reads return zero
    assert_oob_zero_R7: assert property (@(posedge clk) disable iff (rst)
        host_req && !host_we && host_off[16] |=> host_rdata == 8'h00);
endmodule

// File: tb/sim_vram_window_mapper.sv
module sim_vram_window_mapper;
    localparam int CLK_P = 10;
    localparam int AW    = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_idx = 0, reg_wdata = 0, reg_rdata;
    logic host_req = 0, host_we = 0;
    logic [16:0] host_off = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic host_rvalid, mem_en, mem_we;
    logic [7:0] mem_lane_en, mem_wdata;
    logic [8*AW-1:0] mem_addr;
    logic [63:0] mem_rdata = '0;

    int n_tests = 0, n_fail = 0, n_mem_ops = 0;
    bit done = 0;
    logic [7:0] vmem [int unsigned];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    vram_window_mapper #(.VRAM_AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
        .host_we(host_we), .host_off(host_off), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_en(mem_en),
        .mem_we(mem_we), .mem_lane_en(mem_lane_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // synchronous video memory model
    always @(posedge clk) begin
        if (mem_en) begin
            n_mem_ops++;
            for (int i = 0; i < 8; i++) begin
                int unsigned a;
                a = int'(mem_addr[i*AW +: AW]);
                mem_rdata[i*8 +: 8] <= vmem.exists(a) ? vmem[a] : 8'h00;
                if (mem_we && mem_lane_en[i]) vmem[a] = mem_wdata;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_at(input int unsigned a);
        return vmem.exists(a) ? vmem[a] : 8'h00;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected rvalid", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {24'h0, host_rdata}, {24'h0, e});
            end
        end
    end

    task automatic reg_w(input logic sel, input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_chk(input logic sel, input logic [7:0] idx, input logic [7:0] exp,
                           input string tag);
        @(negedge clk);
        reg_sel = sel; reg_idx = idx;
        #1;
        check(tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic host_wr(input logic [16:0] off, input logic [7:0] d);
        @(negedge clk);
        host_req = 1; host_we = 1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic host_rd(input logic [16:0] off, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_req = 1; host_we = 0; host_off = off;
        @(negedge clk);
        host_req = 0;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int ops;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        reg_chk(0, 8'h09, 8'h00, "R1 bank0 reset");
        reg_chk(0, 8'h0B, 8'h00, "R1 ext reset");
        reg_chk(0, 8'h05, 8'h00, "R1 mode reset");
        reg_chk(1, 8'h02, 8'h00, "R1 pmask reset");
        check("R1 rvalid reset", {31'h0, host_rvalid}, 0);
        // R2 register map
        reg_w(0, 8'h09, 8'h03); reg_chk(0, 8'h09, 8'h03, "R2 bank0");
        reg_w(0, 8'h0A, 8'h05); reg_chk(0, 8'h0A, 8'h05, "R2 bank1");
        reg_w(1, 8'h04, 8'h08); reg_chk(1, 8'h04, 8'h08, "R2 memmode");
        reg_w(0, 8'h07, 8'h5A); reg_chk(0, 8'h07, 8'h00, "R2 unlisted index");
        // R3 mode register
        reg_w(0, 8'h05, 8'h7F); reg_chk(0, 8'h05, 8'h7B, "R3 mode narrow wm");
        reg_w(0, 8'h0B, 8'h02);
        reg_w(0, 8'h05, 8'h7C); reg_chk(0, 8'h05, 8'h7C, "R3 mode wide wm");
        reg_w(0, 8'h0B, 8'h00); reg_chk(0, 8'h05, 8'h78, "R3 mode readback trimmed");
        // R4 extension clearing
        reg_w(0, 8'h0B, 8'h0A);
        reg_w(0, 8'h00, 8'hF3); reg_chk(0, 8'h00, 8'hF3, "R4 setrst full");
        reg_w(0, 8'h01, 8'hE1);
        reg_w(1, 8'h02, 8'hFF); reg_chk(1, 8'h02, 8'hFF, "R4 pmask full");
        reg_w(0, 8'h0B, 8'h00);
        reg_chk(0, 8'h00, 8'h03, "R4 setrst cleared");
        reg_chk(0, 8'h01, 8'h01, "R4 ensr cleared");
        reg_chk(1, 8'h02, 8'h0F, "R4 pmask cleared");
        reg_w(1, 8'h02, 8'hF6); reg_chk(1, 8'h02, 8'h06, "R4 pmask write trimmed");
        // R8 chained, bank0 = 3
        host_wr(17'h00010, 8'hA5);
        check("R8 chained write", {24'h0, mem_at(32'h3010)}, 32'hA5);
        check("R8 chained neighbour", {24'h0, mem_at(32'h3011)}, 32'h00);
        host_rd(17'h00010, 8'hA5, "R8 chained read");
        // R5 split window
        reg_w(0, 8'h0B, 8'h01);
        host_wr(17'h08004, 8'h11);
        host_wr(17'h00004, 8'h22);
        host_wr(17'h0C000, 8'h33);
        check("R5 upper half bank1", {24'h0, mem_at(32'h5004)}, 32'h11);
        check("R5 lower half bank0", {24'h0, mem_at(32'h3004)}, 32'h22);
        check("R5 upper half top", {24'h0, mem_at(32'h9000)}, 32'h33);
        host_rd(17'h08004, 8'h11, "R5 split read");
        reg_w(0, 8'h0B, 8'h00);
        host_wr(17'h08004, 8'h44);
        check("R5 unsplit full offset", {24'h0, mem_at(32'hB004)}, 32'h44);
        // R6 coarse granularity
        reg_w(0, 8'h0B, 8'h20);
        host_wr(17'h00020, 8'h55);
        check("R6 16KB base", {24'h0, mem_at(32'hC020)}, 32'h55);
        // R7 out of range
        reg_w(0, 8'h0B, 8'h00);
        ops = n_mem_ops;
        host_wr(17'h10010, 8'h99);
        host_rd(17'h10010, 8'h00, "R7 oob read zero");
        @(negedge clk);
        check("R7 no memory request", ops, n_mem_ops);
        check("R7 memory unchanged", {24'h0, mem_at(32'h3010)}, 32'hA5);
        // R9 unchained narrow
        reg_w(1, 8'h04, 8'h00);
        reg_w(0, 8'h09, 8'h01);
        reg_w(0, 8'h05, 8'h00);
        reg_w(1, 8'h02, 8'h01); host_wr(17'h00002, 8'h30);
        reg_w(1, 8'h02, 8'h04); host_wr(17'h00002, 8'h03);
        check("R9 lane0 addr", {24'h0, mem_at(32'h4008)}, 32'h30);
        check("R9 lane2 addr", {24'h0, mem_at(32'h400A)}, 32'h03);
        check("R9 masked lane1", {24'h0, mem_at(32'h4009)}, 32'h00);
        reg_w(1, 8'h02, 8'h05); host_rd(17'h00002, 8'h33, "R9 OR merge");
        reg_w(1, 8'h02, 8'h02); host_rd(17'h00002, 8'h00, "R9 masked read");
        // R10 unchained wide
        reg_w(0, 8'h0B, 8'h0A);
        reg_w(0, 8'h05, 8'h04);
        reg_w(1, 8'h02, 8'h81); host_wr(17'h00010, 8'h5C);
        check("R10 wm4 lane0", {24'h0, mem_at(32'h4080)}, 32'h5C);
        check("R10 wm4 lane7", {24'h0, mem_at(32'h4087)}, 32'h5C);
        check("R10 wm4 masked lane4", {24'h0, mem_at(32'h4084)}, 32'h00);
        reg_w(1, 8'h02, 8'h80); host_rd(17'h00010, 8'h5C, "R10 wide read");
        reg_w(0, 8'h05, 8'h01); host_wr(17'h00011, 8'h66);
        check("R10 wm1 wide", {24'h0, mem_at(32'h408F)}, 32'h66);
        reg_w(0, 8'h0B, 8'h08);
        reg_w(1, 8'h02, 8'h01); host_wr(17'h00011, 8'h77);
        check("R10 wm1 narrow without ext", {24'h0, mem_at(32'h4044)}, 32'h77);
        reg_w(0, 8'h0B, 8'h0A);
        reg_w(0, 8'h05, 8'h05);
        reg_w(1, 8'h02, 8'h02); host_wr(17'h00012, 8'h12);
        check("R10 wm5 wide", {24'h0, mem_at(32'h4091)}, 32'h12);
        // R11 wrap
        reg_w(1, 8'h04, 8'h08);
        reg_w(0, 8'h0B, 8'h20);
        reg_w(0, 8'h09, 8'hFF);
        host_wr(17'h0FFFF, 8'hE7);
        check("R11 chained wrap", {24'h0, mem_at(32'h0BFFF)}, 32'hE7);
        host_rd(17'h0FFFF, 8'hE7, "R11 wrapped read");
        reg_w(1, 8'h04, 8'h00);
        reg_w(0, 8'h0B, 8'h2A);
        reg_w(0, 8'h05, 8'h04);
        reg_w(1, 8'h02, 8'h80);
        host_wr(17'h02001, 8'h9D);
        check("R11 unchained wrap", {24'h0, mem_at(32'h0000F)}, 32'h9D);
        // R12 same-cycle register write and host access
        reg_w(1, 8'h04, 8'h08);
        reg_w(0, 8'h0B, 8'h00);
        reg_w(0, 8'h09, 8'h02);
        @(negedge clk);
        reg_wr = 1; reg_sel = 0; reg_idx = 8'h09; reg_wdata = 8'h06;
        host_req = 1; host_we = 1; host_off = 17'h00001; host_wdata = 8'hBE;
        @(negedge clk);
        reg_wr = 0; host_req = 0; host_we = 0;
        check("R12 old bank used", {24'h0, mem_at(32'h2001)}, 32'hBE);
        check("R12 new bank untouched", {24'h0, mem_at(32'h6001)}, 32'h00);
        host_rd(17'h00001, 8'h00, "R12 read via new bank");
        host_wr(17'h00001, 8'hCF);
        check("R12 new bank write", {24'h0, mem_at(32'h6001)}, 32'hCF);
        repeat (3) @(negedge clk);
        check("R12 all reads answered", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule